// File: doc/BRIEF.md
# Storage Bus Instruction Register Loader

This block sits where a 36-bit word read from core storage arrives on the shared storage bus. Positions run from the sign (S, index 0) through 35. The block decides when that bus is gated into the CPU. It captures the gated word in the storage register and extracts the operation field into a 10-position instruction register. It also decides when the bus may pass through the channel data switches and the channel address switches.

The CPU side follows cycle-type signals (instruction or execute) and a one-hot phase input that steps through the phases of each cycle. In an instruction cycle the bus is gated on one phase. The storage register loads on the next phase, and the instruction register is decoded on the phase after that. In an execute cycle, gating and loading happen on their own phases, and only while store control is low. Decoding picks between two rules. A word with position 1 or 2 set carries a short prefix code. Any other word carries a full nine-bit opcode in positions 3 to 11.

Every output is registered and changes on the rising clock edge that samples the qualifying inputs.

Top module: `sbus_loader`

## Requirements
- R1: While `rst` is high at a rising edge, the storage register, the instruction register, `cpu_gate`, both channel enables and both channel outputs become zero after that edge.
- R2: In an instruction cycle, `phase` bit `PH_I_GATE` (default 1) raises `cpu_gate` after the edge. `cpu_gate` stays high while `cyc_instr` is high, or while `cyc_exec` is high with `store_ctl` low, and falls after the first edge at which neither holds.
- R3: At an edge with `cyc_instr`, `cpu_gate` and `phase` bit `PH_I_LOAD` (default 2) all high, `sreg` takes the whole 36-bit bus, positions S and 1 to 35.
- R4: In an execute cycle with `store_ctl` low, `phase` bit `PH_E_GATE` (default 5) raises `cpu_gate`. At `phase` bit `PH_E_LOAD` (default 6) with `cpu_gate` high, `sreg` takes the whole bus.
- R5: An execute cycle with `store_ctl` high never raises `cpu_gate` and never changes `sreg`.
- R6: At an edge with `cyc_instr`, `cpu_gate` and `phase` bit `PH_I_DEC` (default 3) high, and bus position 1 or 2 set, `ireg` takes S to position 0, bus 1 to position 8 and bus 2 to position 9. Positions 1 to 7 are cleared.
- R7: At the same decode edge with bus positions 1 and 2 both clear, `ireg` positions 0 to 9 take bus positions S, 3, 4, ... 11 in that order.
- R8: `ireg` does not change at any edge other than a decode edge as defined in R6.
- R9: `chan_data_en` becomes high after an edge where `cyc_chan` is high, or where `cyc_exec` and `load_chan_op` are both high, and `chan_data` then holds the bus from that edge. Otherwise both are zero after the edge.
- R10: `chan_addr_en` becomes high after an edge where `lookahead_op` is high, and `chan_addr` then holds bus positions 21 to 35. Otherwise both are zero after the edge.
- R11: `sreg` does not change at any edge that is not a load edge as defined in R3 or R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_instr | input | 1 | Instruction cycle in progress |
| cyc_exec | input | 1 | Execute cycle in progress |
| cyc_chan | input | 1 | Channel (B) cycle in progress |
| store_ctl | input | 1 | Store control; blocks execute-cycle reads |
| load_chan_op | input | 1 | Current execute cycle belongs to a reset-and-load or load-channel instruction |
| lookahead_op | input | 1 | Look-ahead address control operation active |
| phase | input | NPH | One-hot phase within the cycle |
| sbus | input | 36 | Storage bus, index 0 = S, index n = position n |
| cpu_gate | output | 1 | Bus gated to the CPU |
| sreg | output | 36 | Storage register |
| ireg | output | 10 | Instruction register, positions S and 1 to 9 |
| chan_data_en | output | 1 | Channel input switches open |
| chan_data | output | 36 | Word passed to the data channels |
| chan_addr_en | output | 1 | Channel address switches open |
| chan_addr | output | 15 | Bus positions 21 to 35 passed to the channels |

## Verification
Suppose the gate flag is stuck or drops too early. The storage register then misses or takes a word at the load phase, and this shows on `sreg` one edge after that phase. A wrong prefix test or wrong field routing shows on `ireg` one edge after the decode phase. Stale switch state shows on the channel outputs at the very next edge. Random cycle walks with fresh bus words at every phase make each error visible within one cycle of the phase that exposes it.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int WORD_W = 36;
  localparam int IR_W   = 10;
  typedef logic [0:WORD_W-1] word_t;
  typedef logic [0:IR_W-1]   ir_t;
endpackage

// File: rtl/sbus_gate_ctl.sv
module sbus_gate_ctl #(
  parameter int NPH       = 8,
  parameter int PH_I_GATE = 1,
  parameter int PH_I_LOAD = 2,
  parameter int PH_E_GATE = 5,
  parameter int PH_E_LOAD = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cyc_instr,
  input  logic           cyc_exec,
  input  logic           store_ctl,
  input  logic [NPH-1:0] phase,
  output logic           gate_q,
  output logic           load_en
);
  logic exec_rd, reading, set_gate;

  assign exec_rd  = cyc_exec & ~store_ctl;
  assign reading  = cyc_instr | exec_rd;
  assign set_gate = (cyc_instr & phase[PH_I_GATE]) | (exec_rd & phase[PH_E_GATE]);
  assign load_en  = gate_q & ((cyc_instr & phase[PH_I_LOAD]) | (exec_rd & phase[PH_E_LOAD]));

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= set_gate | (gate_q & reading);
  end
endmodule

// File: rtl/sbus_opdecode.sv
module sbus_opdecode
  import sbus_pkg::*;
#(
  parameter int NPH      = 8,
  parameter int PH_I_DEC = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cyc_instr,
  input  logic           gate_q,
  input  logic [NPH-1:0] phase,
  input  word_t          cpu_bus,
  output ir_t            ireg
);
  ir_t nxt;
  logic prefix;

  assign prefix = cpu_bus[1] | cpu_bus[2];

  always_comb begin
    nxt = '0;
    if (prefix) begin
      nxt[0] = cpu_bus[0];
      nxt[8] = cpu_bus[1];
      nxt[9] = cpu_bus[2];
    end else begin
      nxt[0] = cpu_bus[0];
      for (int i = 1; i < IR_W; i++) nxt[i] = cpu_bus[i+2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                      ireg <= '0;
    else if (cyc_instr & gate_q & phase[PH_I_DEC]) ireg <= nxt;
  end
endmodule

// File: rtl/sbus_chan_switch.sv
module sbus_chan_switch
  import sbus_pkg::*;
#(
  parameter int ADDR_LO = 21,
  localparam int ADDR_W = WORD_W - ADDR_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_chan,
  input  logic              cyc_exec,
  input  logic              load_chan_op,
  input  logic              lookahead_op,
  input  word_t             sbus,
  output logic              data_en,
  output word_t             data_q,
  output logic              addr_en,
  output logic [0:ADDR_W-1] addr_q
);
  logic d_open;
  assign d_open = cyc_chan | (cyc_exec & load_chan_op);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_en <= 1'b0;
      data_q  <= '0;
      addr_en <= 1'b0;
      addr_q  <= '0;
    end else begin
      data_en <= d_open;
      data_q  <= d_open ? sbus : '0;
      addr_en <= lookahead_op;
      addr_q  <= lookahead_op ? sbus[ADDR_LO:WORD_W-1] : '0;
    end
  end
endmodule

// File: rtl/sbus_loader.sv
module sbus_loader
  import sbus_pkg::*;
#(
  parameter int NPH       = 8,
  parameter int PH_I_GATE = 1,
  parameter int PH_I_LOAD = 2,
  parameter int PH_I_DEC  = 3,
  parameter int PH_E_GATE = 5,
  parameter int PH_E_LOAD = 6,
  parameter int ADDR_LO   = 21,
  localparam int ADDR_W   = WORD_W - ADDR_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_instr,
  input  logic              cyc_exec,
  input  logic              cyc_chan,
  input  logic              store_ctl,
  input  logic              load_chan_op,
  input  logic              lookahead_op,
  input  logic [NPH-1:0]    phase,
  input  logic [0:WORD_W-1] sbus,
  output logic              cpu_gate,
  output logic [0:WORD_W-1] sreg,
  output logic [0:IR_W-1]   ireg,
  output logic              chan_data_en,
  output logic [0:WORD_W-1] chan_data,
  output logic              chan_addr_en,
  output logic [0:ADDR_W-1] chan_addr
);
  logic  load_en;
  word_t cpu_bus;

  sbus_gate_ctl #(
    .NPH(NPH), .PH_I_GATE(PH_I_GATE), .PH_I_LOAD(PH_I_LOAD),
    .PH_E_GATE(PH_E_GATE), .PH_E_LOAD(PH_E_LOAD)
  ) u_gate (
    .clk(clk), .rst(rst), .cyc_instr(cyc_instr), .cyc_exec(cyc_exec),
    .store_ctl(store_ctl), .phase(phase), .gate_q(cpu_gate), .load_en(load_en)
  );

  assign cpu_bus = cpu_gate ? sbus : '0;

  always_ff @(posedge clk) begin
    if (rst)          sreg <= '0;
    else if (load_en) sreg <= cpu_bus;
  end

  sbus_opdecode #(.NPH(NPH), .PH_I_DEC(PH_I_DEC)) u_dec (
    .clk(clk), .rst(rst), .cyc_instr(cyc_instr), .gate_q(cpu_gate),
    .phase(phase), .cpu_bus(cpu_bus), .ireg(ireg)
  );

  sbus_chan_switch #(.ADDR_LO(ADDR_LO)) u_chan (
    .clk(clk), .rst(rst), .cyc_chan(cyc_chan), .cyc_exec(cyc_exec),
    .load_chan_op(load_chan_op), .lookahead_op(lookahead_op), .sbus(sbus),
    .data_en(chan_data_en), .data_q(chan_data), .addr_en(chan_addr_en),
    .addr_q(chan_addr)
  );
endmodule

// File: rtl/sbus_loader_chk.sv
module sbus_loader_chk #(
  parameter int NPH       = 8,
  parameter int PH_I_LOAD = 2,
  parameter int PH_I_DEC  = 3,
  parameter int PH_E_LOAD = 6,
  parameter int W         = 36,
  parameter int AW        = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          cyc_instr,
  input logic          cyc_exec,
  input logic          cyc_chan,
  input logic          store_ctl,
  input logic          load_chan_op,
  input logic          lookahead_op,
  input logic [NPH-1:0] phase,
  input logic [0:W-1]  sbus,
  input logic          cpu_gate,
  input logic [0:W-1]  sreg,
  input logic [0:9]    ireg,
  input logic          chan_data_en,
  input logic [0:W-1]  chan_data,
  input logic          chan_addr_en,
  input logic [0:AW-1] chan_addr
);
  logic dec_edge, load_edge;
  assign dec_edge  = cyc_instr & cpu_gate & phase[PH_I_DEC];
  assign load_edge = cpu_gate & ((cyc_instr & phase[PH_I_LOAD]) |
                     (cyc_exec & ~store_ctl & phase[PH_E_LOAD]));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sreg == '0 && ireg == '0 && !cpu_gate && !chan_data_en && !chan_addr_en)); // R1
  AST_STORE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (cyc_exec && store_ctl && !cyc_instr) |=> !cpu_gate); // R5
  AST_PREFIX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dec_edge && (sbus[1] || sbus[2])) |=> ireg[1:7] == '0); // R6
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dec_edge |=> $stable(ireg)); // R8
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_edge |=> $stable(sreg)); // R11
  AST_CHAN_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !(cyc_chan || (cyc_exec && load_chan_op)) |=> (!chan_data_en && chan_data == '0)); // R9
  AST_ADDR_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !lookahead_op |=> (!chan_addr_en && chan_addr == '0)); // R10
endmodule

bind sbus_loader sbus_loader_chk #(
  .NPH(NPH), .PH_I_LOAD(PH_I_LOAD), .PH_I_DEC(PH_I_DEC), .PH_E_LOAD(PH_E_LOAD),
  .W(sbus_pkg::WORD_W), .AW(ADDR_W)
) u_chk (.*);

// File: tb/sbus_loader_test.sv
module sbus_loader_test;
  localparam int NPH = 8;
  localparam int PIG = 1, PIL = 2, PID = 3, PEG = 5, PEL = 6;

  logic clk = 0, rst = 1;
  logic cyc_instr = 0, cyc_exec = 0, cyc_chan = 0, store_ctl = 0, load_chan_op = 0, lookahead_op = 0;
  logic [NPH-1:0] phase = '0;
  logic [0:35] sbus = '0;
  logic cpu_gate, chan_data_en, chan_addr_en;
  logic [0:35] sreg, chan_data;
  logic [0:9] ireg;
  logic [0:14] chan_addr;

  int vectors = 0, miss = 0;
  bit done = 0;

  // bench model state
  logic m_gate = 0, m_den = 0, m_aen = 0;
  logic [0:35] m_sr = '0, m_cd = '0;
  logic [0:9] m_ir = '0;
  logic [0:14] m_ca = '0;

  sbus_loader uut (.*);

  always #5 clk = ~clk;

  function automatic logic [0:9] ir_expect(input logic [0:35] w);
    logic [0:9] r;
    r = '0;
    if (w[1] | w[2]) begin r[0] = w[0]; r[8] = w[1]; r[9] = w[2]; end   // R6
    else begin r[0] = w[0]; for (int i = 1; i < 10; i++) r[i] = w[i+2]; end  // R7
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model one edge from current inputs (requirement semantics)
  task automatic model_edge;
    logic rd, ld;
    if (rst) begin
      m_gate = 0; m_sr = '0; m_ir = '0; m_den = 0; m_cd = '0; m_aen = 0; m_ca = '0;  // R1
    end else begin
      rd = cyc_exec & ~store_ctl;
      ld = m_gate & ((cyc_instr & phase[PIL]) | (rd & phase[PEL]));
      if (m_gate & cyc_instr & phase[PID]) m_ir = ir_expect(sbus);
      if (ld) m_sr = sbus;
      m_gate = (cyc_instr & phase[PIG]) | (rd & phase[PEG]) | (m_gate & (cyc_instr | rd));
      m_den = cyc_chan | (cyc_exec & load_chan_op);
      m_cd  = m_den ? sbus : '0;
      m_aen = lookahead_op;
      m_ca  = lookahead_op ? sbus[21:35] : '0;
    end
  endtask

  task automatic step;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2/R4/R5 cpu_gate", 64'(cpu_gate), 64'(m_gate));
    chk("R3/R4/R11 sreg", 64'(sreg), 64'(m_sr));
    chk("R6/R7/R8 ireg", 64'(ireg), 64'(m_ir));
    chk("R9 chan_data_en", 64'(chan_data_en), 64'(m_den));
    chk("R9 chan_data", 64'(chan_data), 64'(m_cd));
    chk("R10 chan_addr_en", 64'(chan_addr_en), 64'(m_aen));
    chk("R10 chan_addr", 64'(chan_addr), 64'(m_ca));
  endtask

  // walk one full cycle; kind 0 instr, 1 exec, 2 exec with store
  task automatic run_cycle(input int kind, input logic [0:35] fixed, input bit use_fixed);
    cyc_instr = (kind == 0);
    cyc_exec  = (kind != 0);
    store_ctl = (kind == 2);
    for (int p = 0; p < NPH; p++) begin
      phase = NPH'(1) << p;
      sbus = use_fixed ? fixed : {$urandom, $urandom} >> 28;
      cyc_chan = ($urandom % 3 == 0);
      load_chan_op = ($urandom % 4 == 0);
      lookahead_op = ($urandom % 3 == 0);
      step();
    end
    cyc_instr = 0; cyc_exec = 0; store_ctl = 0; phase = '0;
    step();
  endtask

  initial begin
    void'($urandom(32'd1959));
    @(negedge clk);
    step(); step();
    chk("R1 reset sreg", 64'(sreg), 64'd0);
    chk("R1 reset ireg", 64'(ireg), 64'd0);
    chk("R1 reset gate", 64'(cpu_gate), 64'd0);
    rst = 0;
    // directed: prefix via bit1, prefix via bit2, full opcode, store blocked
    run_cycle(0, 36'h4_0000_0000 | 36'h0_FF00_0ABC, 1);  // R6 bit1 set
    chk("R6 prefix ireg", 64'(ireg), 64'(ir_expect(36'h4_FF00_0ABC)));
    run_cycle(0, 36'hA_7FC0_0000, 1);                    // R6 S and bit2
    chk("R6 prefix bit2", 64'(ireg), 64'(10'b1000000001));
    run_cycle(0, 36'h9_FF00_0001, 1);                    // R7 full
    chk("R7 full ireg", 64'(ireg), 64'(10'b1111111111));
    chk("R3 sreg full word", 64'(sreg), 64'(36'h9_FF00_0001));
    run_cycle(2, 36'h1_2345_6789, 1);                    // R5
    chk("R5 store holds sreg", 64'(sreg), 64'(36'h9_FF00_0001));
    run_cycle(1, 36'h3_0000_7FFF, 1);                    // R4
    chk("R4 exec load", 64'(sreg), 64'(36'h3_0000_7FFF));
    chk("R8 exec keeps ireg", 64'(ireg), 64'(10'b1111111111));
    for (int n = 0; n < 400; n++) run_cycle($urandom % 3, '0, 0);
    rst = 1; step();
    chk("R1 reset again", 64'(sreg), 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      vectors++; miss++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule